// File: doc/BRIEF.md
# RAM Segment Write Guard

The guard sits beside a RAM write path and rules on every write the moment it is presented. Software programs up to `NSEG` address segments, each a half-open range of word addresses `[start, stop)`, with separate enables for user-mode and supervisor-mode accesses. One mode input sets how the segments are read. In block mode they are forbidden regions. In allow-list mode they are the only places a write may land.

For each write the guard takes the word address, the privilege flag and a doubleword flag. It returns `acc_allow` in the same cycle. When a presented write is refused, the guard latches a fault status word and the byte address of the write on that clock edge. A small configuration port writes and reads back the segment registers. A sticky error flag records any attempt to set a reserved bit.

Top module: `wp_guard`

## Requirements
- R1: Configuration register `cfg_sel` = 2·s selects the start register of segment s. Its write data holds the start word address in bits 22:0 and the enable field in bits 24:23. `cfg_sel` = 2·s+1 selects the stop register of segment s, whose bits 22:0 hold the stop word address. `cfg_rdata` returns, combinationally, the start address with the enable field in place, or the stop address, with all other bits zero.
- R2: A segment hits when the access mode is enabled, the word address is at least start, and the word address is strictly below stop. Enable bit 0 covers user accesses (`acc_super`=0) and enable bit 1 covers supervisor accesses. `acc_allow` is combinational, and it is 1 whenever `acc_valid` is 0.
- R3: For a doubleword write (`acc_dword`=1), the stop comparison uses the word address with bit 0 forced to 1. The start comparison uses the address unchanged.
- R4: With `prot_block`=1, a write that hits any segment is refused.
- R5: With `prot_block`=0, a write is refused unless it hits at least one segment.
- R6: When every segment's enable field is zero, every write is allowed in either mode.
- R7: On the clock edge of a presented write that is refused, `flt_status` becomes 16'h8018 (code 3 in bits 6:3, write flag in bit 15) and `flt_addr` becomes the word address shifted left by two. Allowed writes and cycles without `acc_valid` leave both unchanged.
- R8: A start-register write with any of bits 31:25 set, or a stop-register write with any of bits 31:23 set, sets `cfg_err`. The flag stays set until reset. The register fields are still written.
- R9: After reset, all segment registers, both fault registers and `cfg_err` are zero, so protection is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | SELW (2) | Register select: segment index in the upper bits, bit 0 picks stop (1) or start (0) |
| cfg_wdata | input | DW (32) | Configuration write data |
| cfg_rdata | output | DW (32) | Read-back of the selected register |
| cfg_err | output | 1 | Sticky reserved-bit write error |
| prot_block | input | 1 | 1: segments are forbidden; 0: segments are the allow-list |
| acc_valid | input | 1 | A RAM write is presented this cycle |
| acc_waddr | input | AW (23) | Word address of the write within RAM |
| acc_super | input | 1 | 1 for a supervisor access, 0 for user |
| acc_dword | input | 1 | The write is a doubleword |
| acc_allow | output | 1 | Write may proceed |
| flt_status | output | 16 | Last fault status |
| flt_addr | output | AW+2 (25) | Byte address of the last refused write |

## Verification
The bench builds the guard with its default parameters: two segments, 23-bit word addresses and 32-bit registers. With two segments it can place one segment enabled only for supervisor accesses next to another enabled only for user accesses. It can also check that a hit in either segment is enough in allow-list mode. The full 23-bit width puts the topmost word address 0x7FFFFF within reach. That address cannot sit below any stop value, so it shows the exclusive upper bound at the end of RAM. A stop value one word past an even address shows the doubleword widening of the upper-bound check.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // fault status word layout
    localparam int unsigned STAT_W        = 16;
    localparam int unsigned FLT_CODE_LSB  = 3;
    localparam int unsigned FLT_CODE_W    = 4;
    localparam int unsigned FLT_WRITE_BIT = 15;
    localparam logic [FLT_CODE_W-1:0] FLT_CODE_PROT = 4'd3;

    // width of one segment enable field: user bit, supervisor bit
    localparam int unsigned EN_W = 2;

    typedef enum logic {
        MODE_ALLOW_LIST = 1'b0,
        MODE_BLOCK      = 1'b1
    } prot_mode_e;

    function automatic logic [STAT_W-1:0] prot_fault_word();
        logic [STAT_W-1:0] w;
        w = '0;
        w[FLT_CODE_LSB +: FLT_CODE_W] = FLT_CODE_PROT;
        w[FLT_WRITE_BIT] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/wp_seg_regs.sv
module wp_seg_regs
    import wp_pkg::*;
#(
    parameter int unsigned NSEG = 2,
    parameter int unsigned AW   = 23,
    parameter int unsigned DW   = 32,
    localparam int unsigned SEGW = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int unsigned SELW = SEGW + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [SELW-1:0]               sel,
    input  logic [DW-1:0]                 wdata,
    output logic [DW-1:0]                 rdata,
    output logic                          err,
    output logic [NSEG-1:0][AW-1:0]       seg_start,
    output logic [NSEG-1:0][AW-1:0]       seg_stop,
    output logic [NSEG-1:0][EN_W-1:0]     seg_en
);

    localparam int unsigned START_RSV_LSB = AW + EN_W;
    localparam int unsigned STOP_RSV_LSB  = AW;

    typedef struct packed {
        logic [NSEG-1:0][AW-1:0]   start;
        logic [NSEG-1:0][AW-1:0]   stop;
        logic [NSEG-1:0][EN_W-1:0] en;
        logic                      err;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [SEGW-1:0] seg_idx;
    logic            pick_stop;
    logic            idx_ok;
    logic            rsv_start;
    logic            rsv_stop;

    always_comb begin
        seg_idx   = sel[SELW-1:1];
        pick_stop = sel[0];
        idx_ok    = (int'(seg_idx) < NSEG);
        rsv_start = |(wdata >> START_RSV_LSB);
        rsv_stop  = |(wdata >> STOP_RSV_LSB);

        regs_d = regs_q;
        if (we && idx_ok) begin
            if (pick_stop) begin
                regs_d.stop[seg_idx] = wdata[AW-1:0];
                if (rsv_stop) begin
                    regs_d.err = 1'b1;
                end
            end else begin
                regs_d.start[seg_idx] = wdata[AW-1:0];
                regs_d.en[seg_idx]    = wdata[AW +: EN_W];
                if (rsv_start) begin
                    regs_d.err = 1'b1;
                end
            end
        end

        rdata = '0;
        if (idx_ok) begin
            if (pick_stop) begin
                rdata[AW-1:0] = regs_q.stop[seg_idx];
            end else begin
                rdata[AW-1:0]     = regs_q.start[seg_idx];
                rdata[AW +: EN_W] = regs_q.en[seg_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign err       = regs_q.err;
    assign seg_start = regs_q.start;
    assign seg_stop  = regs_q.stop;
    assign seg_en    = regs_q.en;

endmodule

// File: rtl/wp_seg_match.sv
module wp_seg_match
    import wp_pkg::*;
#(
    parameter int unsigned AW = 23
) (
    input  logic [AW-1:0]   start,
    input  logic [AW-1:0]   stop,
    input  logic [EN_W-1:0] en,
    input  logic [AW-1:0]   waddr,
    input  logic            super_acc,
    input  logic            dword,
    output logic            hit
);

    logic [AW-1:0] last_word;
    logic          mode_on;

    always_comb begin
        // the second word of a doubleword must also lie below stop
        last_word = {waddr[AW-1:1], waddr[0] | dword};
        mode_on   = super_acc ? en[1] : en[0];
        hit       = mode_on && (waddr >= start) && (last_word < stop);
    end

endmodule

// File: rtl/wp_fault.sv
module wp_fault
    import wp_pkg::*;
#(
    parameter int unsigned AW = 23,
    localparam int unsigned BAW = AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [AW-1:0]     waddr,
    output logic [STAT_W-1:0] status,
    output logic [BAW-1:0]    byte_addr
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [BAW-1:0]    addr;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (capture) begin
            flt_d.status = prot_fault_word();
            flt_d.addr   = {waddr, 2'b00};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '0;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign status    = flt_q.status;
    assign byte_addr = flt_q.addr;

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int unsigned NSEG = 2,
    parameter int unsigned AW   = 23,
    parameter int unsigned DW   = 32,
    localparam int unsigned SEGW = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int unsigned SELW = SEGW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SELW-1:0]   cfg_sel,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    output logic              cfg_err,
    input  logic              prot_block,
    input  logic              acc_valid,
    input  logic [AW-1:0]     acc_waddr,
    input  logic              acc_super,
    input  logic              acc_dword,
    output logic              acc_allow,
    output logic [STAT_W-1:0] flt_status,
    output logic [AW+1:0]     flt_addr
);

    logic [NSEG-1:0][AW-1:0]   seg_start;
    logic [NSEG-1:0][AW-1:0]   seg_stop;
    logic [NSEG-1:0][EN_W-1:0] seg_en;
    logic [NSEG-1:0]           seg_hit;
    logic                      checking;
    logic                      any_hit;
    logic                      refuse;
    prot_mode_e                mode;

    wp_seg_regs #(
        .NSEG (NSEG),
        .AW   (AW),
        .DW   (DW)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .err       (cfg_err),
        .seg_start (seg_start),
        .seg_stop  (seg_stop),
        .seg_en    (seg_en)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        wp_seg_match #(
            .AW (AW)
        ) i_match (
            .start     (seg_start[g]),
            .stop      (seg_stop[g]),
            .en        (seg_en[g]),
            .waddr     (acc_waddr),
            .super_acc (acc_super),
            .dword     (acc_dword),
            .hit       (seg_hit[g])
        );
    end

    always_comb begin
        mode     = prot_mode_e'(prot_block);
        checking = |seg_en;
        any_hit  = |seg_hit;
        refuse   = 1'b0;
        if (acc_valid && checking) begin
            if (mode == MODE_BLOCK) begin
                refuse = any_hit;
            end else begin
                refuse = !any_hit;
            end
        end
        acc_allow = !refuse;
    end

    wp_fault #(
        .AW (AW)
    ) i_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (refuse),
        .waddr     (acc_waddr),
        .status    (flt_status),
        .byte_addr (flt_addr)
    );

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk
    import wp_pkg::*;
#(
    parameter int unsigned NSEG = 2,
    parameter int unsigned AW   = 23,
    parameter int unsigned DW   = 32,
    localparam int unsigned SEGW = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int unsigned SELW = SEGW + 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [SELW-1:0]           cfg_sel,
    input logic [DW-1:0]             cfg_wdata,
    input logic                      cfg_err,
    input logic                      acc_valid,
    input logic [AW-1:0]             acc_waddr,
    input logic                      acc_allow,
    input logic [STAT_W-1:0]         flt_status,
    input logic [AW+1:0]             flt_addr,
    input logic [NSEG-1:0][EN_W-1:0] seg_en
);

    a_r2_idle_allows: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> acc_allow);

    a_r6_unarmed_allows: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && seg_en == '0) |-> acc_allow);

    a_r7_refusal_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow) |=>
            (flt_status == 16'h8018) && (flt_addr == {$past(acc_waddr), 2'b00}));

    a_r7_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_allow) |=> ($stable(flt_status) && $stable(flt_addr)));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r8_start_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel[0] && (int'(cfg_sel >> 1) < NSEG)
            && (|(cfg_wdata >> (AW + 2)))) |=> cfg_err);

    a_r8_stop_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel[0] && (int'(cfg_sel >> 1) < NSEG)
            && (|(cfg_wdata >> AW))) |=> cfg_err);

endmodule

bind wp_guard wp_guard_chk #(
    .NSEG (NSEG),
    .AW   (AW),
    .DW   (DW)
) i_wp_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .cfg_err    (cfg_err),
    .acc_valid  (acc_valid),
    .acc_waddr  (acc_waddr),
    .acc_allow  (acc_allow),
    .flt_status (flt_status),
    .flt_addr   (flt_addr),
    .seg_en     (seg_en)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 23;
    localparam int DW = 32;
    localparam int NVEC = 19;

    typedef struct packed {
        logic        blk;
        logic [1:0]  en0;
        logic [22:0] s0;
        logic [22:0] e0;
        logic [1:0]  en1;
        logic [22:0] s1;
        logic [22:0] e1;
        logic [22:0] a;
        logic        sup;
        logic        dw;
        logic        ok;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 2'd0, 23'h0,     23'h0,     2'd0, 23'h0,      23'h0,      23'h100,    1'b0, 1'b0, 1'b1}, // R6 nothing armed
        '{1'b1, 2'd0, 23'h100,   23'h200,   2'd0, 23'h100,    23'h200,    23'h150,    1'b0, 1'b0, 1'b1}, // R6 ranges set, no enables
        '{1'b1, 2'd1, 23'h100,   23'h200,   2'd0, 23'h0,      23'h0,      23'h100,    1'b0, 1'b0, 1'b0}, // R4 start inclusive
        '{1'b1, 2'd1, 23'h100,   23'h200,   2'd0, 23'h0,      23'h0,      23'h1FF,    1'b0, 1'b0, 1'b0}, // R4 last word
        '{1'b1, 2'd1, 23'h100,   23'h200,   2'd0, 23'h0,      23'h0,      23'h200,    1'b0, 1'b0, 1'b1}, // R2 stop exclusive
        '{1'b1, 2'd1, 23'h100,   23'h200,   2'd0, 23'h0,      23'h0,      23'h0FF,    1'b0, 1'b0, 1'b1}, // R2 below start
        '{1'b1, 2'd1, 23'h100,   23'h200,   2'd0, 23'h0,      23'h0,      23'h150,    1'b1, 1'b0, 1'b1}, // R2 supervisor not enabled
        '{1'b1, 2'd1, 23'h100,   23'h1FF,   2'd0, 23'h0,      23'h0,      23'h1FE,    1'b0, 1'b0, 1'b0}, // R3 single word hits
        '{1'b1, 2'd1, 23'h100,   23'h1FF,   2'd0, 23'h0,      23'h0,      23'h1FE,    1'b0, 1'b1, 1'b1}, // R3 doubleword misses
        '{1'b0, 2'd0, 23'h0,     23'h0,     2'd2, 23'h400,    23'h500,    23'h450,    1'b1, 1'b0, 1'b1}, // R5 supervisor inside
        '{1'b0, 2'd0, 23'h0,     23'h0,     2'd2, 23'h400,    23'h500,    23'h450,    1'b0, 1'b0, 1'b0}, // R5 user not enabled
        '{1'b0, 2'd0, 23'h0,     23'h0,     2'd2, 23'h400,    23'h500,    23'h500,    1'b1, 1'b0, 1'b0}, // R5 at stop
        '{1'b0, 2'd3, 23'h0,     23'h10,    2'd3, 23'h7FFF00, 23'h7FFFFF, 23'h7FFFFE, 1'b0, 1'b0, 1'b1}, // R5 second segment
        '{1'b0, 2'd3, 23'h0,     23'h10,    2'd3, 23'h7FFF00, 23'h7FFFFF, 23'h7FFFFF, 1'b0, 1'b0, 1'b0}, // R5 top word
        '{1'b0, 2'd3, 23'h0,     23'h10,    2'd3, 23'h7FFF00, 23'h7FFFFF, 23'h5,      1'b1, 1'b0, 1'b1}, // R5 first segment
        '{1'b0, 2'd3, 23'h0,     23'h10,    2'd3, 23'h7FFF00, 23'h7FFFFF, 23'h20,     1'b1, 1'b0, 1'b0}, // R5 between
        '{1'b1, 2'd2, 23'h100,   23'h200,   2'd1, 23'h300,    23'h400,    23'h350,    1'b1, 1'b0, 1'b1}, // R4 user-only segment
        '{1'b1, 2'd2, 23'h100,   23'h200,   2'd1, 23'h300,    23'h400,    23'h150,    1'b1, 1'b0, 1'b0}, // R4 supervisor segment
        '{1'b0, 2'd1, 23'h100,   23'h1FF,   2'd0, 23'h0,      23'h0,      23'h1FE,    1'b0, 1'b1, 1'b0}  // R3 allow-list doubleword
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic          cfg_err;
    logic          prot_block = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_waddr = '0;
    logic          acc_super = 1'b0;
    logic          acc_dword = 1'b0;
    logic          acc_allow;
    logic [15:0]   flt_status;
    logic [AW+1:0] flt_addr;

    int total = 0;
    int bad = 0;
    logic [15:0]   m_stat;
    logic [AW+1:0] m_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_guard i_wp_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_err    (cfg_err),
        .prot_block (prot_block),
        .acc_valid  (acc_valid),
        .acc_waddr  (acc_waddr),
        .acc_super  (acc_super),
        .acc_dword  (acc_dword),
        .acc_allow  (acc_allow),
        .flt_status (flt_status),
        .flt_addr   (flt_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_stat = '0;
        m_addr = '0;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, output logic [31:0] data);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        data = cfg_rdata;
    endtask

    // presents one write; returns the combinational decision, leaves valid low after the edge
    task automatic access(input logic [22:0] a, input logic sup, input logic dw, input logic vld,
                          output logic allow);
        @(negedge clk);
        acc_valid = vld;
        acc_waddr = a;
        acc_super = sup;
        acc_dword = dw;
        #1;
        allow = acc_allow;
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        al;

        m_stat = '0;
        m_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        for (int s = 0; s < 4; s++) begin
            cfg_read(2'(s), rd);
            check("R9 register after reset", rd, 32'h0);
        end
        check("R9 cfg_err after reset", {31'b0, cfg_err}, 32'h0);
        check("R9 flt_status after reset", {16'b0, flt_status}, 32'h0);
        check("R9 flt_addr after reset", {7'b0, flt_addr}, 32'h0);
        access(23'h123, 1'b0, 1'b0, 1'b1, al);
        check("R9 R6 write allowed after reset", {31'b0, al}, 32'h1);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            prot_block = v.blk;
            cfg_write(2'd0, {7'b0, v.en0, v.s0});
            cfg_write(2'd1, {9'b0, v.e0});
            cfg_write(2'd2, {7'b0, v.en1, v.s1});
            cfg_write(2'd3, {9'b0, v.e1});
            access(v.a, v.sup, v.dw, 1'b1, al);
            check($sformatf("R2 R3 R4 R5 R6 vector %0d decision", i), {31'b0, al}, {31'b0, v.ok});
            if (!v.ok) begin
                m_stat = 16'h8018;
                m_addr = {v.a, 2'b00};
            end
            check($sformatf("R7 vector %0d status", i), {16'b0, flt_status}, {16'b0, m_stat});
            check($sformatf("R7 vector %0d address", i), {7'b0, flt_addr}, {7'b0, m_addr});
        end

        // R7 no capture without acc_valid; R2 idle allow
        prot_block = 1'b1;
        cfg_write(2'd0, {7'b0, 2'd3, 23'h0});
        cfg_write(2'd1, {9'b0, 23'h7FFFFF});
        access(23'h40, 1'b0, 1'b0, 1'b0, al);
        check("R2 idle allow", {31'b0, al}, 32'h1);
        check("R7 idle leaves status", {16'b0, flt_status}, {16'b0, m_stat});
        check("R7 idle leaves address", {7'b0, flt_addr}, {7'b0, m_addr});
        access(23'h44, 1'b1, 1'b0, 1'b1, al);
        check("R7 capture refused", {31'b0, al}, 32'h0);
        check("R7 capture status", {16'b0, flt_status}, 32'h8018);
        check("R7 capture address", {7'b0, flt_addr}, 32'h110);

        // R1 read-back and R8 reserved bits
        do_reset();
        cfg_write(2'd2, 32'h0181_2345);
        cfg_read(2'd2, rd);
        check("R1 start read-back with enables", rd, 32'h0181_2345);
        cfg_write(2'd3, 32'h007F_FFFF);
        cfg_read(2'd3, rd);
        check("R1 stop read-back", rd, 32'h007F_FFFF);
        cfg_read(2'd0, rd);
        check("R1 other segment untouched", rd, 32'h0);
        check("R8 legal writes leave error clear", {31'b0, cfg_err}, 32'h0);
        cfg_write(2'd0, 32'h0200_0011);
        check("R8 start reserved bit 25", {31'b0, cfg_err}, 32'h1);
        cfg_read(2'd0, rd);
        check("R8 start still written", rd, 32'h0000_0011);
        cfg_write(2'd0, 32'h0000_0001);
        check("R8 error sticky", {31'b0, cfg_err}, 32'h1);
        do_reset();
        check("R9 error cleared by reset", {31'b0, cfg_err}, 32'h0);
        cfg_write(2'd1, 32'h0080_0000);
        check("R8 stop reserved bit 23", {31'b0, cfg_err}, 32'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule